// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-First Mode

This block is a register-mapped watchdog built around a down-counter. Software sets a reload value, turns counting on, and writes the kick location from time to time to restart the count. If software stops kicking and the count runs out, the block asks the chip for a reset. Optionally, software can arm a one-shot warning mode. In that mode the first expiry raises a status flag and reloads the counter instead of resetting. The mode bit then clears itself, so the next expiry forces the reset.

The count advances only on cycles where the tick-enable input is high. Three external activity inputs (hibernation timer, wake timer, debug session) can each freeze the count. Each one acts only while its own enable bit is set. The register bus is a plain synchronous port: byte address, write strobe, write data, and a combinational read-data output.

Top module: `wdog_timer`

## Requirements
- R1: After reset the reload register reads 0xFFFF, the counter reads 0xFFFF, control, status and interrupt-enable read 0, and both irq_o and rst_req_o are low.
- R2: Registers sit at byte offsets reload 0x00, control 0x04, kick 0x08, count 0x0C, status 0x10 (bit 0), interrupt-enable 0x14 (bit 0). In control only bits 0, 2, 3, 4 and 9 are stored, so writing 0xFFFF reads back 0x021D.
- R3: A control write that takes bit 0 from 0 to 1 loads the counter from the reload register. While bit 0 is 1, each cycle with tick_i high and no enabled stall lowers the count by one.
- R4: While control bit 0 is 0 the count holds on ticks and no expiry action occurs.
- R5: Control bits 2, 3 and 4 freeze the count while stall_hib_i, stall_wake_i or stall_dbg_i, respectively, is high. A stall input whose enable bit is clear has no effect.
- R6: A write of any value to the kick offset reloads the counter from the reload register. A kick in the same cycle as an expiry wins, and no expiry action occurs.
- R7: With control bit 9 clear, an active tick at count 0 gives rst_req_o high for exactly one cycle, starting the cycle after that tick, and reloads the counter.
- R8: With control bit 9 set, an active tick at count 0 clears bit 9, sets status bit 0 and reloads the counter, and no reset pulse is issued. The following expiry issues the reset pulse.
- R9: irq_o is high exactly while status bit 0 and interrupt-enable bit 0 are both 1. Writing 1 to status bit 0 clears it.
- R10: Writes to the count offset leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 5 | Byte address of register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for addr_i |
| tick_i | input | 1 | Count tick enable |
| stall_hib_i | input | 1 | Hibernation-timer activity |
| stall_wake_i | input | 1 | Wake-timer activity |
| stall_dbg_i | input | 1 | Debug activity |
| irq_o | output | 1 | Warning interrupt level |
| rst_req_o | output | 1 | One-cycle chip reset request |

## Verification
The count is driven with tick bursts of chosen lengths. Bursts with enable set and cleared separate real decrements from held counts. Bursts with each stall input raised, once with its enable bit and once without, show that a stall takes effect only when enabled. Expiry is tried in reset mode, in warning mode followed by a second expiry, and with a kick landing on the expiring tick. Together these show which of reset pulse, status flag and reload each case produces. Interrupt-enable is toggled against the status flag to confirm the interrupt gating.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_LOAD = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_STS  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 5'h14;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_STL0 = 2;  // three stall enables at 2..4
  localparam int unsigned CB_MODE = 9;
  localparam int unsigned N_STALL = 3;

  typedef struct packed {
    logic               irq_mode;
    logic [N_STALL-1:0] stall_en;  // [0]=hib [1]=wake [2]=dbg
    logic               en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              expire_irq_i,
  output logic [CNT_W-1:0]  load_val_o,
  output ctrl_t             ctrl_o,
  output logic              reload_o,
  output logic              irq_o
);
  logic [CNT_W-1:0] load_q;
  ctrl_t            ctrl_q, ctrl_d;
  logic             sts_q, ien_q;
  logic             wr_load, wr_ctrl, wr_kick, wr_sts, wr_ien;

  assign wr_load = we_i && (addr_i == OFS_LOAD);
  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_kick = we_i && (addr_i == OFS_KICK);
  assign wr_sts  = we_i && (addr_i == OFS_STS);
  assign wr_ien  = we_i && (addr_i == OFS_IEN);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en       = wdata_i[CB_EN];
      ctrl_d.stall_en = wdata_i[CB_STL0 +: N_STALL];
      ctrl_d.irq_mode = wdata_i[CB_MODE];
    end
    if (expire_irq_i) ctrl_d.irq_mode = 1'b0;  // one-shot warning
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '1;
      ctrl_q <= '0;
      sts_q  <= 1'b0;
      ien_q  <= 1'b0;
    end else begin
      if (wr_load) load_q <= wdata_i[CNT_W-1:0];
      ctrl_q <= ctrl_d;
      if (expire_irq_i)                 sts_q <= 1'b1;
      else if (wr_sts && wdata_i[0])    sts_q <= 1'b0;
      if (wr_ien) ien_q <= wdata_i[0];
    end
  end

  assign reload_o   = wr_kick || (wr_ctrl && wdata_i[CB_EN] && !ctrl_q.en);
  assign load_val_o = load_q;
  assign ctrl_o     = ctrl_q;
  assign irq_o      = sts_q && ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LOAD: rdata_o[CNT_W-1:0] = load_q;
      OFS_CTRL: begin
        rdata_o[CB_EN]              = ctrl_q.en;
        rdata_o[CB_STL0 +: N_STALL] = ctrl_q.stall_en;
        rdata_o[CB_MODE]            = ctrl_q.irq_mode;
      end
      OFS_CNT:  rdata_o[CNT_W-1:0] = cnt_i;
      OFS_STS:  rdata_o[0] = sts_q;
      OFS_IEN:  rdata_o[0] = ien_q;
      default:  rdata_o = '0;
    endcase
  end

  a_r8_mode_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_irq_i |=> !ctrl_q.irq_mode);
  a_r8_sts_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_irq_i |=> sts_q);
  a_r9_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sts && wdata_i[0] && !expire_irq_i) |=> !irq_o);
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  ctrl_t              ctrl_i,
  input  logic [N_STALL-1:0] stall_i,
  input  logic [CNT_W-1:0]   load_val_i,
  input  logic               reload_i,
  output logic [CNT_W-1:0]   cnt_o,
  output logic               expire_irq_o,
  output logic               rst_req_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [N_STALL-1:0] stall_hit;
  logic               active, expire, rst_q;

  for (genvar g = 0; g < N_STALL; g++) begin : g_stall
    assign stall_hit[g] = ctrl_i.stall_en[g] && stall_i[g];
  end

  assign active       = tick_i && ctrl_i.en && !(|stall_hit);
  assign expire       = active && (cnt_q == '0) && !reload_i;
  assign expire_irq_o = expire && ctrl_i.irq_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '1;
      rst_q <= 1'b0;
    end else begin
      rst_q <= expire && !ctrl_i.irq_mode;
      if (reload_i || expire) cnt_q <= load_val_i;
      else if (active)        cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |=> !rst_req_o);
  a_r4_hold_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !reload_i) |=> $stable(cnt_q));
  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|stall_hit) && !reload_i) |=> $stable(cnt_q));
  a_r8_no_reset_in_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_irq_o |=> !rst_req_o);
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  input  logic              stall_hib_i,
  input  logic              stall_wake_i,
  input  logic              stall_dbg_i,
  output logic              irq_o,
  output logic              rst_req_o
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] cnt, load_val;
  logic             reload, expire_irq;

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .expire_irq_i(expire_irq), .load_val_o(load_val),
    .ctrl_o(ctrl), .reload_o(reload), .irq_o
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .ctrl_i(ctrl),
    .stall_i({stall_dbg_i, stall_wake_i, stall_hib_i}),
    .load_val_i(load_val), .reload_i(reload), .cnt_o(cnt),
    .expire_irq_o(expire_irq), .rst_req_o
  );
endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0, tick = 1'b0;
  logic [15:0] wdata = '0, rdata;
  logic        s_hib = 1'b0, s_wake = 1'b0, s_dbg = 1'b0;
  logic        irq, rst_req;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdog_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .stall_hib_i(s_hib), .stall_wake_i(s_wake),
    .stall_dbg_i(s_dbg), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [4:0] a, logic [15:0] exp);
    addr = a; #1;
    chk(req, rdata, exp);
  endtask

  task automatic tick_n(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset;
    rd_chk("R1 load", 5'h00, 16'hFFFF);
    rd_chk("R1 ctrl", 5'h04, 16'h0000);
    rd_chk("R1 sts", 5'h10, 16'h0000);
    rd_chk("R1 ien", 5'h14, 16'h0000);
    rd_chk("R1 cnt", 5'h0C, 16'hFFFF);
    chk("R1 irq", {15'b0, irq}, 16'h0);
    chk("R1 rst_req", {15'b0, rst_req}, 16'h0);
  endtask

  task automatic t_mask;
    wr(5'h04, 16'hFFFF);
    rd_chk("R2 ctrl mask", 5'h04, 16'h021D);
    wr(5'h04, 16'h0000);
    wr(5'h00, 16'h1234);
    rd_chk("R2 load rw", 5'h00, 16'h1234);
  endtask

  task automatic t_count;
    wr(5'h00, 16'd5);
    wr(5'h04, 16'h0001);
    rd_chk("R3 start load", 5'h0C, 16'd5);
    tick_n(3);
    rd_chk("R3 decrement", 5'h0C, 16'd2);
  endtask

  task automatic t_hold;
    wr(5'h04, 16'h0000);
    tick_n(4);
    rd_chk("R4 hold", 5'h0C, 16'd2);
    chk("R4 no reset", {15'b0, rst_req}, 16'h0);
    wr(5'h0C, 16'h1234);
    rd_chk("R10 cnt ro", 5'h0C, 16'd2);
  endtask

  task automatic t_stall;
    wr(5'h04, 16'h0001);
    wr(5'h04, 16'h0005);
    rd_chk("R3 reenable reload", 5'h0C, 16'd5);
    s_hib = 1'b1;
    tick_n(2);
    rd_chk("R5 hib stall", 5'h0C, 16'd5);
    s_hib = 1'b0; s_wake = 1'b1;
    tick_n(1);
    rd_chk("R5 unenabled stall", 5'h0C, 16'd4);
    s_wake = 1'b0;
    wr(5'h04, 16'h001D);
    s_dbg = 1'b1;
    tick_n(2);
    rd_chk("R5 dbg stall", 5'h0C, 16'd4);
    s_dbg = 1'b0;
    wr(5'h08, 16'h00A5);
    rd_chk("R6 kick", 5'h0C, 16'd5);
    wr(5'h04, 16'h0001);
  endtask

  task automatic t_reset_expiry;
    wr(5'h00, 16'd2);
    wr(5'h08, 16'h0000);
    tick_n(3);
    chk("R7 pulse", {15'b0, rst_req}, 16'h1);
    rd_chk("R7 reload", 5'h0C, 16'd2);
    @(negedge clk);
    chk("R7 one cycle", {15'b0, rst_req}, 16'h0);
  endtask

  task automatic t_irq_expiry;
    wr(5'h14, 16'h0001);
    wr(5'h04, 16'h0201);
    tick_n(3);
    chk("R8 no reset", {15'b0, rst_req}, 16'h0);
    rd_chk("R8 sts", 5'h10, 16'h0001);
    rd_chk("R8 mode cleared", 5'h04, 16'h0001);
    rd_chk("R8 reload", 5'h0C, 16'd2);
    chk("R9 irq high", {15'b0, irq}, 16'h1);
    tick_n(3);
    chk("R8 second expiry resets", {15'b0, rst_req}, 16'h1);
    wr(5'h10, 16'h0001);
    rd_chk("R9 w1c", 5'h10, 16'h0000);
    chk("R9 irq low", {15'b0, irq}, 16'h0);
    wr(5'h14, 16'h0000);
    wr(5'h04, 16'h0201);
    tick_n(3);
    rd_chk("R9 sts masked", 5'h10, 16'h0001);
    chk("R9 irq masked", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_kick_wins;
    wr(5'h04, 16'h0001);
    wr(5'h08, 16'h0000);
    tick_n(2);
    rd_chk("R6 at zero", 5'h0C, 16'd0);
    @(negedge clk); addr = 5'h08; wdata = 16'h0033; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    chk("R6 kick beats expiry", {15'b0, rst_req}, 16'h0);
    rd_chk("R6 kick reload", 5'h0C, 16'd2);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask();
        t_count();
        t_hold();
        t_stall();
        t_reset_expiry();
        t_irq_expiry();
        t_kick_wins();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule